// File: doc/BRIEF.md
# Reaction Time Measurement Core

This block measures how long a person takes to respond to a light. An external delay generator sends a single-cycle start pulse. On that pulse the core turns the stimulus lamp on and starts a four-decade BCD millisecond count, which advances on a 1 ms tick enable. The person then presses a stop button. The core turns the lamp off, freezes the count and raises a flag that says a measurement is ready. The frozen value stays until the next synchronous reset.

The stop button is asynchronous to the clock. It passes through a two-flop synchroniser, and only its rising edge is used. If the button is pressed before the lamp lights, nothing happens. If the button is held down, it does not count as a new press. When the count reaches 9.999 s it stops there instead of wrapping to zero.

Top module: `rxn_timer_core`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `digits` = 0, `lamp` low and `ready` low.
- R2: A `start` pulse seen in the idle phase turns `lamp` on from the next cycle. A `start` pulse in any other phase has no effect.
- R3: While the lamp is on, each edge with `ms_tick` high adds 1 ms to the count. Ticks in the idle phase or the frozen phase leave `digits` unchanged.
- R4: `digits` holds four BCD decades. Bits [3:0] are milliseconds, [7:4] tens of ms, [11:8] hundreds of ms and [15:12] seconds. Each decade goes from 9 to 0 and carries one into the next higher decade.
- R5: At 9999 (9.999 s) the count holds on further ticks and does not wrap. The lamp stays on.
- R6: A rising edge of `stop_btn` while the lamp is on freezes the count. Suppose `stop_btn` is first sampled high at edge j after being low at edge j-1. Then `lamp` goes low and `ready` goes high after edge j+2. A tick at edge j+1 is counted. A tick at edge j+2 is not.
- R7: Stop presses while the lamp has not yet lit are ignored. The lamp stays off, `ready` stays low and the count stays 0. A level that stays high makes no further press.
- R8: Once frozen, `digits`, `lamp` and `ready` stay unchanged until reset, whatever arrives on `start`, `stop_btn` or `ms_tick`.
- R9: `ready` is high exactly in the frozen phase and never together with `lamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle enable once per millisecond |
| start | input | 1 | Single-cycle pulse that lights the lamp and starts timing |
| stop_btn | input | 1 | Raw stop button level, asynchronous |
| lamp | output | 1 | Stimulus lamp drive |
| digits | output | 16 | Four BCD decades of elapsed ms |
| ready | output | 1 | A frozen measurement is available |

## Verification
The hardest state to reach from the ports is the saturated count. Reaching it needs ten thousand ticks while the lamp stays on. The stimulus gets there by raising `ms_tick` on every cycle, which runs the count past 9999 with no wait between ticks. It then checks that the count holds at 9999 and that a later stop still freezes it. The bench also lines up a tick with the exact edge at which the synchronised press takes effect, and it holds the button high across a trigger so that the level-versus-edge rule is exercised.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
    localparam int unsigned BCD_W   = 4;
    localparam logic [3:0]  BCD_MAX = 4'd9;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HELD = 2'd2
    } phase_t;
endpackage

// File: rtl/rxn_stop_edge.sv
module rxn_stop_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = btn;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.last = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign press = st_q.chain[STAGES-1] & ~st_q.last;

    // R7: a held level produces one press only
    a_r7_single_press: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);
endmodule

// File: rtl/rxn_bcd_chain.sv
module rxn_bcd_chain
    import rxn_pkg::*;
#(
    parameter int unsigned DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    inc,
    output bcd_t [DIGITS-1:0]       val,
    output logic                    full
);
    bcd_t [DIGITS-1:0] val_d, val_q;
    logic [DIGITS:0]   carry;

    always_comb begin
        val_d    = val_q;
        carry    = '0;
        carry[0] = inc;
        full     = 1'b1;
        for (int i = 0; i < int'(DIGITS); i++) begin
            if (carry[i]) begin
                val_d[i] = (val_q[i] == BCD_MAX) ? '0 : val_q[i] + 4'd1;
            end
            carry[i+1] = carry[i] && (val_q[i] == BCD_MAX);
            full       = full && (val_q[i] == BCD_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign val = val_q;

    generate
        for (genvar g = 0; g < int'(DIGITS); g++) begin : g_chk
            // R4: every decade stays a legal BCD code
            a_r4_digit_legal: assert property (@(posedge clk) disable iff (rst)
                val_q[g] <= BCD_MAX);
        end
    endgenerate

    // R3: one step of the lowest decade per enabled cycle
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> (val_q[0] == (($past(val_q[0]) == BCD_MAX) ? 4'd0 : $past(val_q[0]) + 4'd1)));
    // R3: no enable, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(val_q));
endmodule

// File: rtl/rxn_phase_ctrl.sv
module rxn_phase_ctrl
    import rxn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic press,
    input  logic tick,
    input  logic full,
    output logic inc,
    output logic lamp,
    output logic ready
);
    typedef struct packed {
        phase_t phase;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        inc  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: if (start) st_d.phase = PH_RUN;
            PH_RUN: begin
                if (press) st_d.phase = PH_HELD;
                else       inc = tick && !full;
            end
            PH_HELD: st_d.phase = PH_HELD;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_IDLE};
        else     st_q <= st_d;
    end

    assign lamp  = (st_q.phase == PH_RUN);
    assign ready = (st_q.phase == PH_HELD);

    // R2: start while idle lights the lamp next cycle
    a_r2_arm: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_IDLE && start) |=> lamp);
    // R7: without start the idle phase stays dark
    a_r7_idle_dark: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_IDLE && !start) |=> (!lamp && !ready));
    // R5: never step past the all-nines value
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        inc |-> !full);
    // R6: press while running freezes
    a_r6_stop: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RUN && press) |=> (!lamp && ready));
    // R8: frozen phase is left only by reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
endmodule

// File: rtl/rxn_timer_core.sv
module rxn_timer_core
    import rxn_pkg::*;
#(
    parameter int unsigned DIGITS      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned DW         = DIGITS * BCD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ms_tick,
    input  logic          start,
    input  logic          stop_btn,
    output logic          lamp,
    output logic [DW-1:0] digits,
    output logic          ready
);
    logic              press;
    logic              inc;
    logic              full;
    bcd_t [DIGITS-1:0] val;

    rxn_stop_edge #(.STAGES(SYNC_STAGES)) u_stop (
        .clk   (clk),
        .rst   (rst),
        .btn   (stop_btn),
        .press (press)
    );

    rxn_phase_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .press (press),
        .tick  (ms_tick),
        .full  (full),
        .inc   (inc),
        .lamp  (lamp),
        .ready (ready)
    );

    rxn_bcd_chain #(.DIGITS(DIGITS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (inc),
        .val  (val),
        .full (full)
    );

    assign digits = val;

    // R1: reset clears everything visible
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (digits == '0 && !lamp && !ready));
    // R8: frozen value does not move
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        ready |=> $stable(digits));
    // R9: flag and lamp are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ready && lamp));
endmodule

// File: tb/rxn_timer_core_tb.sv
module rxn_timer_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic        start = 1'b0;
    logic        stop_btn = 1'b0;
    logic        lamp;
    logic [15:0] digits;
    logic        ready;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit live  = 1'b0;
    bit over  = 1'b0;

    // behavioural reference
    int m_ms    = 0;
    int m_phase = 0;     // 0 idle, 1 lamp on, 2 frozen
    bit m_hist[$];       // stop samples, newest first

    always #5 clk = ~clk;

    rxn_timer_core dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .start(start),
        .stop_btn(stop_btn), .lamp(lamp), .digits(digits), .ready(ready)
    );

    function automatic logic [15:0] to_bcd(int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic bit hist_at(int i);
        return (i < m_hist.size()) ? m_hist[i] : 1'b0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        live <= 1'b1;
        if (rst) begin
            m_ms = 0; m_phase = 0; m_hist.delete();
        end else begin
            bit pressed;
            pressed = hist_at(1) && !hist_at(2);
            case (m_phase)
                0: if (start) m_phase = 1;
                1: if (pressed) m_phase = 2;
                   else if (ms_tick && m_ms < 9999) m_ms++;
                default: ;
            endcase
            m_hist.push_front(stop_btn);
            if (m_hist.size() > 4) void'(m_hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (live && !over) begin
            check(digits == to_bcd(m_ms), "R3/R4 digits", digits, to_bcd(m_ms));
            check(lamp == (m_phase == 1), "R2/R6 lamp", lamp, m_phase == 1);
            check(ready == (m_phase == 2), "R9 ready", ready, m_phase == 2);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; ms_tick = 0; start = 0; stop_btn = 0;
        step(2); rst = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; step(1); start = 1'b0;
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; step(1); ms_tick = 1'b0;
            if (gap > 0) step(gap);
        end
    endtask

    initial begin
        step(3);
        // R1 reset state
        check(digits == 16'h0 && !lamp && !ready, "R1 reset", digits, 0);
        rst = 1'b0;

        // R7 press before the lamp lights
        stop_btn = 1; step(5); stop_btn = 0; step(3);
        ticks(3, 1);
        check(!lamp && !ready && digits == 0, "R7 early press ignored", digits, 0);

        // R2 start, R3 ticks with gaps
        pulse_start();
        check(lamp == 1, "R2 lamp on", lamp, 1);
        ticks(27, 2);
        check(digits == 16'h0027, "R3 count", digits, 16'h0027);

        // R6 tick aligned with freeze edge: sample edge j, tick at j+1 and j+2
        stop_btn = 1; step(1);
        ms_tick = 1; step(2); ms_tick = 0;
        check(digits == 16'h0028 && ready && !lamp, "R6 freeze", digits, 16'h0028);

        // R8 frozen: ticks, start, new press ignored
        stop_btn = 0; step(2); ticks(5, 0); pulse_start();
        stop_btn = 1; step(4); stop_btn = 0; step(2);
        check(digits == 16'h0028 && ready && !lamp, "R8 frozen", digits, 16'h0028);

        // R4 carries across decades
        do_reset();
        check(digits == 0 && !lamp, "R1 reset after freeze", digits, 0);
        pulse_start();
        ticks(1999, 0);
        check(digits == 16'h1999, "R4 carry chain", digits, 16'h1999);
        ticks(1, 0);
        check(digits == 16'h2000, "R4 triple wrap", digits, 16'h2000);

        // R1 reset mid-run
        do_reset();
        check(digits == 0 && !lamp && !ready, "R1 reset mid run", digits, 0);

        // R7 level held across start gives no press
        stop_btn = 1; step(4);
        pulse_start(); ticks(12, 0);
        check(lamp && digits == 16'h0012, "R7 held level", digits, 16'h0012);
        stop_btn = 0; step(2);

        // R5 saturation
        ticks(10010, 0);
        check(digits == 16'h9999 && lamp, "R5 saturate", digits, 16'h9999);
        stop_btn = 1; step(4);
        check(ready && digits == 16'h9999, "R6 stop at max", digits, 16'h9999);
        stop_btn = 0; step(3);

        over = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        bad++; total++;
        over = 1'b1;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule